// File: doc/BRIEF.md
# Memory Self-Test Pattern Sequencer

This block exercises a small single-port RAM with a fixed series of data patterns and reports the first location that reads back wrong. After a start pulse it takes over the memory's enable, write-enable, address and write-data lines. It first writes a solid background, then runs walking and galloping passes in which one base cell holds the complement of the background while the other cells are read back. Every read is compared one cycle later with the value that the pattern says the cell must hold.

Six patterns run back to back with no idle cycles between them. The first wrong word ends the run. The block then raises a fail flag and reports the failing address and the number of the pattern in which the fault appeared. A run with no wrong word ends with done high and fail low. The RAM is not part of the block. It sits outside, with read data registered on the clock edge that samples the read address.

Top module: `mbist_engine`

## Requirements
- R1: After reset, done, fail and mem_en are low. A start sampled high while idle or done clears done, fail, fail_addr and fail_pat on the next edge, and the first memory access is presented in the cycle after that edge.
- R2: Patterns run in this order, numbered 0 to 5 (the number reported in fail_pat): 0 solid with background 0, 1 solid with background all-ones, 2 walking with background 0, 3 walking with background all-ones, 4 galloping with background 0, 5 galloping with background all-ones. The base cell value is the bitwise complement of the background.
- R3: In a solid pattern, the background is written to addresses 0 to N-1 in ascending order, and then addresses 0 to N-1 are read in ascending order.
- R4: In a walking pattern, the background is first written to all addresses in ascending order. Then, for each base b from 0 upward: the complement is written at b, addresses (b+k) mod N are read for k = 1..N-1, b is read, and the background is written back at b.
- R5: In a galloping pattern, the fill and per-base write are the same as in R4. For each k = 1..N-1, address (b+k) mod N is read and then b is read. After that, the background is written back at b, with no further read of b.
- R6: Each access occupies one cycle, and accesses follow each other with no gap inside or between patterns. Write data is always all-zeros or all-ones.
- R7: Read data is taken in the cycle after the read address. On the first wrong word, fail and done are high two cycles after that read was presented, with fail_addr equal to its address and fail_pat equal to its pattern number. mem_en is low from then on.
- R8: When every read matches, mem_en is low for one cycle after the last access, done rises the cycle after that, and fail stays low. done holds until the next accepted start.
- R9: A start sampled while a run is in progress has no effect on the access sequence.
- R10: fail, fail_addr and fail_pat hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (ignored while running) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write when high, read when low (with mem_en) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after the read |
| done | output | 1 | Run finished (pass or fail) |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | ADDR_W | Address of the first mismatching read |
| fail_pat | output | 3 | Pattern number (0 to 5) of the first mismatch |

## Verification
The first access appears in the first cycle after start is sampled. From there, access number k appears k-1 cycles later, and the bench compares each one in its own cycle against a sequence it rebuilds from R3 to R5. A mismatch shows on fail, fail_addr and fail_pat exactly two cycles after the offending read. The bench records the cycle of the last read of every address and checks that gap of two. On a clean run, done is checked low in the drain cycle and high in the cycle after. Faults placed in the bench's memory model (stuck bits, and writes that disturb another cell) each have a first failing address and pattern that follow from the access order.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    localparam int unsigned PAT_W   = 3;
    localparam int unsigned NUM_PAT = 6;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_FILL,
        PH_RD_ALL,
        PH_WR_BASE,
        PH_RD_OTHER,
        PH_RD_BASE_G,
        PH_RD_BASE,
        PH_RESTORE,
        PH_DRAIN,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        PK_SOLID  = 2'd0,
        PK_WALK   = 2'd1,
        PK_GALLOP = 2'd2
    } pat_kind_e;

endpackage

// File: rtl/mbist_pat_decode.sv
module mbist_pat_decode
    import mbist_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [PAT_W-1:0]  pat,
    output pat_kind_e         kind,
    output logic [DATA_W-1:0] bg,
    output logic [DATA_W-1:0] inv
);

    // pattern number: upper bits select the kind, low bit the background
    always_comb begin
        kind = pat_kind_e'(pat[2:1]);
        bg   = {DATA_W{pat[0]}};
        inv  = ~bg;
    end

endmodule

// File: rtl/mbist_seq_fsm.sv
module mbist_seq_fsm
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mismatch,
    input  pat_kind_e         kind,
    input  logic [DATA_W-1:0] bg,
    input  logic [DATA_W-1:0] inv,
    output logic [PAT_W-1:0]  pat,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rd_fire,
    output logic [DATA_W-1:0] rd_exp,
    output logic              clear,
    output logic              done
);

    localparam logic [ADDR_W-1:0] LAST_A   = {ADDR_W{1'b1}};
    localparam logic [PAT_W-1:0]  LAST_PAT = PAT_W'(NUM_PAT - 1);

    typedef struct packed {
        phase_e            phase;
        logic [PAT_W-1:0]  pat;
        logic [ADDR_W-1:0] idx;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ofs;
    } seq_t;

    seq_t seq_d, seq_q;
    logic adv_pat;
    logic running;
    logic [ADDR_W-1:0] other;

    always_comb begin
        seq_d     = seq_q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = seq_q.idx;
        mem_wdata = bg;
        rd_exp    = bg;
        clear     = 1'b0;
        adv_pat   = 1'b0;
        other     = seq_q.base + seq_q.ofs;
        running   = (seq_q.phase != PH_IDLE) && (seq_q.phase != PH_DONE);

        unique case (seq_q.phase)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    clear       = 1'b1;
                    seq_d.phase = PH_FILL;
                    seq_d.pat   = '0;
                    seq_d.idx   = '0;
                    seq_d.base  = '0;
                    seq_d.ofs   = '0;
                end
            end
            PH_FILL: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = seq_q.idx;
                mem_wdata = bg;
                if (seq_q.idx == LAST_A) begin
                    seq_d.idx   = '0;
                    seq_d.base  = '0;
                    seq_d.phase = (kind == PK_SOLID) ? PH_RD_ALL : PH_WR_BASE;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            PH_RD_ALL: begin
                mem_en   = 1'b1;
                mem_addr = seq_q.idx;
                rd_exp   = bg;
                if (seq_q.idx == LAST_A) adv_pat = 1'b1;
                else seq_d.idx = seq_q.idx + 1'b1;
            end
            PH_WR_BASE: begin
                mem_en      = 1'b1;
                mem_we      = 1'b1;
                mem_addr    = seq_q.base;
                mem_wdata   = inv;
                seq_d.ofs   = ADDR_W'(1);
                seq_d.phase = PH_RD_OTHER;
            end
            PH_RD_OTHER: begin
                mem_en   = 1'b1;
                mem_addr = other;
                rd_exp   = bg;
                if (kind == PK_GALLOP) seq_d.phase = PH_RD_BASE_G;
                else if (seq_q.ofs == LAST_A) seq_d.phase = PH_RD_BASE;
                else seq_d.ofs = seq_q.ofs + 1'b1;
            end
            PH_RD_BASE_G: begin
                mem_en   = 1'b1;
                mem_addr = seq_q.base;
                rd_exp   = inv;
                if (seq_q.ofs == LAST_A) begin
                    seq_d.phase = PH_RESTORE;
                end else begin
                    seq_d.ofs   = seq_q.ofs + 1'b1;
                    seq_d.phase = PH_RD_OTHER;
                end
            end
            PH_RD_BASE: begin
                mem_en      = 1'b1;
                mem_addr    = seq_q.base;
                rd_exp      = inv;
                seq_d.phase = PH_RESTORE;
            end
            PH_RESTORE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = seq_q.base;
                mem_wdata = bg;
                if (seq_q.base == LAST_A) begin
                    adv_pat = 1'b1;
                end else begin
                    seq_d.base  = seq_q.base + 1'b1;
                    seq_d.phase = PH_WR_BASE;
                end
            end
            PH_DRAIN: seq_d.phase = PH_DONE;
            default:  seq_d.phase = PH_IDLE;
        endcase

        if (adv_pat) begin
            if (seq_q.pat == LAST_PAT) begin
                seq_d.phase = PH_DRAIN;
            end else begin
                seq_d.pat   = seq_q.pat + 1'b1;
                seq_d.idx   = '0;
                seq_d.phase = PH_FILL;
            end
        end

        if (running && mismatch) seq_d.phase = PH_DONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign pat     = seq_q.pat;
    assign rd_fire = mem_en && !mem_we;
    assign done    = (seq_q.phase == PH_DONE);

    // R6
    wdata_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == '0 || mem_wdata == '1));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start) |=> !(seq_q.phase == PH_FILL && seq_q.pat == '0 && seq_q.idx == '0));

endmodule

// File: rtl/mbist_resp_chk.sv
module mbist_resp_chk
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_exp,
    input  logic [PAT_W-1:0]  rd_pat,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mismatch,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [PAT_W-1:0]  fail_pat
);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp;
        logic [PAT_W-1:0]  pat;
        logic              fail;
        logic [ADDR_W-1:0] fail_addr;
        logic [PAT_W-1:0]  fail_pat;
    } chk_t;

    chk_t chk_d, chk_q;

    always_comb begin
        chk_d      = chk_q;
        mismatch   = chk_q.pend && !chk_q.fail && (mem_rdata != chk_q.exp);
        chk_d.pend = rd_fire;
        chk_d.addr = rd_addr;
        chk_d.exp  = rd_exp;
        chk_d.pat  = rd_pat;
        if (mismatch) begin
            chk_d.fail      = 1'b1;
            chk_d.fail_addr = chk_q.addr;
            chk_d.fail_pat  = chk_q.pat;
        end
        if (clear) begin
            chk_d.pend      = 1'b0;
            chk_d.fail      = 1'b0;
            chk_d.fail_addr = '0;
            chk_d.fail_pat  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign fail      = chk_q.fail;
    assign fail_addr = chk_q.fail_addr;
    assign fail_pat  = chk_q.fail_pat;

    // R10
    sticky_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> (fail && $stable(fail_addr) && $stable(fail_pat)));

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [PAT_W-1:0]  fail_pat
);

    pat_kind_e         kind;
    logic [DATA_W-1:0] bg, inv, rd_exp;
    logic [PAT_W-1:0]  pat;
    logic              mismatch, rd_fire, clear;

    mbist_pat_decode #(.DATA_W(DATA_W)) u_dec (
        .pat(pat), .kind(kind), .bg(bg), .inv(inv)
    );

    mbist_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .mismatch(mismatch),
        .kind(kind), .bg(bg), .inv(inv), .pat(pat),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rd_fire(rd_fire), .rd_exp(rd_exp), .clear(clear), .done(done)
    );

    mbist_resp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
        .clk(clk), .rst_n(rst_n), .clear(clear), .rd_fire(rd_fire),
        .rd_addr(mem_addr), .rd_exp(rd_exp), .rd_pat(pat), .mem_rdata(mem_rdata),
        .mismatch(mismatch), .fail(fail), .fail_addr(fail_addr), .fail_pat(fail_pat)
    );

    // R7
    fail_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> ($past(rd_fire, 2) && fail_addr == $past(mem_addr, 2)));

    // R7
    fail_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && !mem_en));

endmodule

// File: tb/mbist_engine_test.sv
module mbist_engine_test;

    localparam int AW = 3;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mem_en, mem_we, done, fail;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [2:0] fail_pat;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int op_n = 0;
    int last_rd [N];
    logic [DW-1:0] mem [N];

    // fault configuration of the memory model
    bit st_on = 0; int st_addr = 0; logic [DW-1:0] st_and = '1, st_or = '0;
    bit cp_on = 0; int cp_aggr = 0, cp_vic = 0;
    logic [DW-1:0] cp_trig = '0, cp_and = '1, cp_or = '0;

    always #2 clk = ~clk;

    mbist_engine #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_pat(fail_pat)
    );

    initial for (int i = 0; i < N; i++) begin mem[i] = '0; last_rd[i] = 0; end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_en && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (cp_on && int'(mem_addr) == cp_aggr && mem_wdata == cp_trig)
                mem[cp_vic] <= (mem[cp_vic] & cp_and) | cp_or;
        end
        if (mem_en && !mem_we) begin
            if (st_on && int'(mem_addr) == st_addr) mem_rdata <= (mem[mem_addr] & st_and) | st_or;
            else mem_rdata <= mem[mem_addr];
        end
    end

    always @(negedge clk) if (mem_en && !mem_we) last_rd[mem_addr] = cyc;

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic expect_op(input bit we, input int a, input logic [DW-1:0] wd, input string tag);
        string t;
        @(negedge clk);
        op_n++;
        t = (op_n == 101 || op_n == 102) ? "R9" : tag;
        check(mem_en && mem_we == we && int'(mem_addr) == a && (!we || mem_wdata == wd), t,
              $sformatf("op %0d: en=%0b we=%0b addr=%0d wd=%h, expected en=1 we=%0b addr=%0d wd=%h",
                        op_n, mem_en, mem_we, mem_addr, mem_wdata, we, a, wd));
        start = (op_n == 100);
    endtask

    task automatic clean_run();
        logic [DW-1:0] bg;
        int kind;
        string tag;
        op_n = 0;
        @(negedge clk); start = 1'b1;
        for (int p = 0; p < 6; p++) begin
            bg   = (p % 2 == 1) ? '1 : '0;
            kind = p / 2;
            tag  = (kind == 0) ? "R3" : (kind == 1) ? "R4" : "R5";
            for (int a = 0; a < N; a++) expect_op(1'b1, a, bg, (a == 0) ? "R2" : tag);
            if (kind == 0) begin
                for (int a = 0; a < N; a++) expect_op(1'b0, a, bg, tag);
            end else begin
                for (int b = 0; b < N; b++) begin
                    expect_op(1'b1, b, ~bg, tag);
                    for (int k = 1; k < N; k++) begin
                        expect_op(1'b0, (b + k) % N, bg, tag);
                        if (kind == 2) expect_op(1'b0, b, bg, tag);
                    end
                    if (kind == 1) expect_op(1'b0, b, bg, tag);
                    expect_op(1'b1, b, bg, tag);
                end
            end
        end
        check(op_n == 480, "R6", $sformatf("access count %0d, expected 480", op_n));
        @(negedge clk);
        check(!done && !mem_en, "R8", $sformatf("drain: done=%0b en=%0b, expected 0 0", done, mem_en));
        @(negedge clk);
        check(done && !fail, "R8", $sformatf("end: done=%0b fail=%0b, expected 1 0", done, fail));
        repeat (5) @(negedge clk);
        check(done && !mem_en, "R8", $sformatf("hold: done=%0b en=%0b, expected 1 0", done, mem_en));
    endtask

    task automatic fault_run(input int exp_addr, input int exp_pat, input string tag);
        int fcyc;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(!done && !fail && fail_addr == '0 && fail_pat == '0, "R1",
              $sformatf("after start: done=%0b fail=%0b addr=%0d pat=%0d, expected 0 0 0 0",
                        done, fail, fail_addr, fail_pat));
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        fcyc = cyc;
        check(fail, tag, $sformatf("fail=%0b, expected 1", fail));
        check(int'(fail_addr) == exp_addr, tag, $sformatf("fail_addr=%0d, expected %0d", fail_addr, exp_addr));
        check(int'(fail_pat) == exp_pat, "R2", $sformatf("fail_pat=%0d, expected %0d", fail_pat, exp_pat));
        check(fcyc - last_rd[exp_addr] == 2, "R7",
              $sformatf("fail latency %0d cycles, expected 2", fcyc - last_rd[exp_addr]));
        check(!mem_en, "R7", $sformatf("mem_en=%0b after fail, expected 0", mem_en));
        repeat (4) @(negedge clk);
        check(fail && int'(fail_addr) == exp_addr && int'(fail_pat) == exp_pat, "R10",
              $sformatf("held: fail=%0b addr=%0d pat=%0d, expected 1 %0d %0d",
                        fail, fail_addr, fail_pat, exp_addr, exp_pat));
        st_on = 0; cp_on = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !fail && !mem_en, "R1",
              $sformatf("reset: done=%0b fail=%0b en=%0b, expected 0 0 0", done, fail, mem_en));

        clean_run();

        // stuck-at-1 on bit 3 of address 3: first caught by pattern 0
        st_on = 1; st_addr = 3; st_and = '1; st_or = 8'h08;
        fault_run(3, 0, "R3");

        // stuck-at-0 on bit 7 of address 5: first caught by pattern 1
        st_on = 1; st_addr = 5; st_and = 8'h7f; st_or = '0;
        fault_run(5, 1, "R3");

        // writing all-ones at 2 sets bit 0 of 6: caught in pattern 2, base 2
        cp_on = 1; cp_aggr = 2; cp_vic = 6; cp_trig = '1; cp_and = '1; cp_or = 8'h01;
        fault_run(6, 2, "R4");

        // writing all-zeros at 1 clears bit 4 of 2: caught in pattern 3, base 1
        cp_on = 1; cp_aggr = 1; cp_vic = 2; cp_trig = '0; cp_and = 8'hef; cp_or = '0;
        fault_run(2, 3, "R4");

        // fault-free run again after failures
        clean_run();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule